// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block connects an on-chip requester to asynchronous parallel memories such as SRAM, NOR flash or NAND-style parts. Four chip selects each cover one 64 MiB window, so the external space is 256 MiB. A requester gives one access at a time over a valid/ready handshake. The access carries an address, a direction, write data and byte enables. The controller runs the access as three timed phases on the device pins: setup, strobe and hold. When the access completes it returns a one-cycle response.

Every chip select has its own set of static configuration inputs. These give the setup, strobe and hold lengths in clock cycles, kept separately for reads and writes. They also give a turnaround gap, a data bus width of 8 or 16 bits, a mode in which the chip select is asserted only while the strobe is asserted, and a mode in which a device wait pin lengthens the strobe. The turnaround gap is placed ahead of an access. It is inserted only when the access changes chip select or direction relative to the one before it.

Top module: `async_mem_ctrl`

## Requirements
- R1: The two top address bits `req_addr[27:26]` select the chip select. Only that `mem_cs_n` bit goes low. `mem_addr` carries `req_addr[25:0]` unchanged on every cycle in which the chip select is low.
- R2: Counted from the cycle after acceptance, an access runs setup for S cycles, then strobe for T cycles, then hold for H cycles. S, T and H are the selected chip select's values for the access direction. With select-strobe off, the chip select is low for exactly S+T+H cycles.
- R3: A programmed phase length of 0 behaves as 1 cycle.
- R4: A turnaround gap of G cycles (the turnaround value of the new access's chip select) goes ahead of setup. During the gap no chip select or strobe is low. There is no gap on the first access after reset, when G is 0, or when the previous access used the same chip select and the same direction.
- R5: With select-strobe mode on, the chip select is low only during the strobe cycles.
- R6: With extended wait on, a high `mem_wait` bit for that chip select keeps the strobe going past T. The input passes through two flops. If the pin falls on the N-th strobe cycle (N at least T), the strobe lasts N+2 cycles. With extended wait off, the pin has no effect.
- R7: An 8-bit chip select (wide bit 0) drives `mem_dout[15:8]` to 0 and holds `mem_be_n[1]` high. Read data bits [15:8] return as 0. A 16-bit chip select uses all 16 bits and active-low byte enables `~req_be`.
- R8: Read data is taken from `mem_din` on the last strobe cycle. It is returned on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the cycle after the last hold cycle.
- R9: `req_ready` is high only when idle. It is low from the cycle after acceptance until the response cycle, and it is high again in the response cycle.
- R10: `mem_oe_n` is low only during read strobe cycles and `mem_we_n` is low only during write strobe cycles; the two are never low together. During a write, `mem_dout_en` is high and `mem_dout` carries the write data.
- R11: After reset, all chip selects and strobes are high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address; [27:26] chip select, [25:0] offset |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_rd_setup | input | 16 | Read setup cycles, 4 bits per chip select |
| cfg_rd_strobe | input | 16 | Read strobe cycles, 4 bits per chip select |
| cfg_rd_hold | input | 16 | Read hold cycles, 4 bits per chip select |
| cfg_wr_setup | input | 16 | Write setup cycles, 4 bits per chip select |
| cfg_wr_strobe | input | 16 | Write strobe cycles, 4 bits per chip select |
| cfg_wr_hold | input | 16 | Write hold cycles, 4 bits per chip select |
| cfg_turn | input | 16 | Turnaround cycles, 4 bits per chip select |
| cfg_sel_strobe | input | 4 | Select-strobe mode per chip select |
| cfg_ext_wait | input | 4 | Extended-wait mode per chip select |
| cfg_wide | input | 4 | 1 = 16-bit bus, 0 = 8-bit bus |
| mem_wait | input | 4 | Device wait pins, active high, one per chip select |
| mem_din | input | 16 | Data from device |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | 26 | Offset within the window |
| mem_dout | output | 16 | Data to device |
| mem_dout_en | output | 1 | Data driver enable |
| mem_be_n | output | 2 | Byte enables, active low |

## Verification
The bench drives the request at a falling edge, and the request is accepted on the next rising edge. From then on it samples the pins at every falling edge. Sample k is the state reached after k rising edges beyond acceptance. That gives G gap samples, then S setup, T strobe and H hold samples, then the response sample at G+S+T+H+1. Each result is checked at the sample in which it is due. Gap, setup, strobe and hold lengths come from the bench's own counts of pin levels. Read data is checked on the response sample, after `mem_din` has been changed on the first hold sample. The wait pin is released on a known strobe sample, so the two synchronizer flops put the end of the strobe exactly two samples later.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  // A gap is owed when a previous access exists, the gap is non-zero,
  // and chip select or direction differs from that access.
  function automatic logic gap_owed(input logic prev_valid, input logic same_cs,
                                    input logic same_dir, input logic gap_nonzero);
    return prev_valid && gap_nonzero && !(same_cs && same_dir);
  endfunction

endpackage

// File: rtl/amc_cs_decode.sv
module amc_cs_decode #(
  parameter int ADDR_W = 28,
  parameter int NUM_CS = 4,
  parameter int TW     = 4,
  localparam int CS_BITS = $clog2(NUM_CS),
  localparam int OFF_W   = ADDR_W - CS_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 write,
  input  logic [NUM_CS*TW-1:0] rd_setup,
  input  logic [NUM_CS*TW-1:0] rd_strobe,
  input  logic [NUM_CS*TW-1:0] rd_hold,
  input  logic [NUM_CS*TW-1:0] wr_setup,
  input  logic [NUM_CS*TW-1:0] wr_strobe,
  input  logic [NUM_CS*TW-1:0] wr_hold,
  input  logic [NUM_CS*TW-1:0] turn,
  input  logic [NUM_CS-1:0]    sel_strobe,
  input  logic [NUM_CS-1:0]    ext_wait,
  input  logic [NUM_CS-1:0]    wide,
  output logic [CS_BITS-1:0]   cs_idx,
  output logic [OFF_W-1:0]     offset,
  output logic [TW-1:0]        setup_len,
  output logic [TW-1:0]        strobe_len,
  output logic [TW-1:0]        hold_len,
  output logic [TW-1:0]        turn_len,
  output logic                 ss_en,
  output logic                 ew_en,
  output logic                 wide_en
);

  // Phase lengths never drop below one cycle.
  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  function automatic logic [TW-1:0] field(input logic [NUM_CS*TW-1:0] vec,
                                          input logic [CS_BITS-1:0] idx);
    return vec[idx*TW +: TW];
  endfunction

  assign cs_idx = addr[ADDR_W-1 -: CS_BITS];
  assign offset = addr[OFF_W-1:0];

  assign setup_len  = at_least_one(write ? field(wr_setup, cs_idx)  : field(rd_setup, cs_idx));
  assign strobe_len = at_least_one(write ? field(wr_strobe, cs_idx) : field(rd_strobe, cs_idx));
  assign hold_len   = at_least_one(write ? field(wr_hold, cs_idx)   : field(rd_hold, cs_idx));
  assign turn_len   = field(turn, cs_idx);

  assign ss_en   = sel_strobe[cs_idx];
  assign ew_en   = ext_wait[cs_idx];
  assign wide_en = wide[cs_idx];

endmodule

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CS-1:0] wait_pin,
  output logic [NUM_CS-1:0] wait_sync
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sync
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= wait_pin[g];
        stable_q <= meta_q;
      end
    end
    assign wait_sync[g] = stable_q;
  end

endmodule

// File: rtl/amc_seq.sv
module amc_seq import amc_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int TW     = 4,
  parameter int OFF_W  = 26,
  parameter int DW     = 16,
  localparam int CS_BITS = $clog2(NUM_CS),
  localparam int BE_W    = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [DW-1:0]      req_wdata,
  input  logic [BE_W-1:0]    req_be,
  input  logic [CS_BITS-1:0] dec_cs,
  input  logic [TW-1:0]      dec_setup,
  input  logic [TW-1:0]      dec_strobe,
  input  logic [TW-1:0]      dec_hold,
  input  logic [TW-1:0]      dec_turn,
  input  logic               dec_ss,
  input  logic               dec_ew,
  input  logic               dec_wide,
  input  logic [NUM_CS-1:0]  wait_sync,
  input  logic [DW-1:0]      mem_din,
  output phase_e             phase,
  output logic               req_ready,
  output logic [CS_BITS-1:0] cur_cs,
  output logic               cur_write,
  output logic               cur_ss,
  output logic               cur_wide,
  output logic [OFF_W-1:0]   cur_offset,
  output logic [DW-1:0]      cur_wdata,
  output logic [BE_W-1:0]    cur_be,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               ev_accept,
  output logic               ev_extend,
  output logic               ev_capture,
  output logic               ev_done
);

  function automatic logic [DW-1:0] lane_keep(input logic wide);
    return wide ? {DW{1'b1}} : {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
  endfunction

  phase_e             phase_q;
  logic [TW-1:0]      cnt_q;
  logic [TW-1:0]      setup_q, strobe_q, hold_q;
  logic               ew_q;
  logic               last_valid_q, last_wr_q;
  logic [CS_BITS-1:0] last_cs_q;
  logic               cnt_zero, go_gap;

  assign cnt_zero   = (cnt_q == '0);
  assign ev_accept  = (phase_q == PH_IDLE) && req_valid;
  assign go_gap     = gap_owed(last_valid_q, last_cs_q == dec_cs,
                               last_wr_q == req_write, dec_turn != '0);
  assign ev_extend  = (phase_q == PH_STROBE) && cnt_zero && ew_q && wait_sync[cur_cs];
  assign ev_capture = (phase_q == PH_STROBE) && cnt_zero && !ev_extend;
  assign ev_done    = (phase_q == PH_HOLD) && cnt_zero;
  assign req_ready  = (phase_q == PH_IDLE);
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      setup_q      <= '0;
      strobe_q     <= '0;
      hold_q       <= '0;
      ew_q         <= 1'b0;
      cur_cs       <= '0;
      cur_write    <= 1'b0;
      cur_ss       <= 1'b0;
      cur_wide     <= 1'b0;
      cur_offset   <= '0;
      cur_wdata    <= '0;
      cur_be       <= '0;
      last_valid_q <= 1'b0;
      last_wr_q    <= 1'b0;
      last_cs_q    <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (ev_accept) begin
            cur_cs     <= dec_cs;
            cur_write  <= req_write;
            cur_ss     <= dec_ss;
            cur_wide   <= dec_wide;
            cur_offset <= req_offset;
            cur_wdata  <= req_wdata;
            cur_be     <= req_be;
            setup_q    <= dec_setup;
            strobe_q   <= dec_strobe;
            hold_q     <= dec_hold;
            ew_q       <= dec_ew;
            if (go_gap) begin
              phase_q <= PH_TURN;
              cnt_q   <= dec_turn - TW'(1);
            end else begin
              phase_q <= PH_SETUP;
              cnt_q   <= dec_setup - TW'(1);
            end
          end
        end
        PH_TURN: begin
          if (cnt_zero) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_q - TW'(1);
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= strobe_q - TW'(1);
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        PH_STROBE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - TW'(1);
          end else if (ev_capture) begin
            rsp_rdata <= cur_write ? '0 : (mem_din & lane_keep(cur_wide));
            phase_q   <= PH_HOLD;
            cnt_q     <= hold_q - TW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) begin
            phase_q      <= PH_IDLE;
            rsp_valid    <= 1'b1;
            last_valid_q <= 1'b1;
            last_cs_q    <= cur_cs;
            last_wr_q    <= cur_write;
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl import amc_pkg::*; #(
  parameter int ADDR_W = 28,
  parameter int NUM_CS = 4,
  parameter int TW     = 4,
  parameter int DW     = 16,
  localparam int CS_BITS = $clog2(NUM_CS),
  localparam int OFF_W   = ADDR_W - CS_BITS,
  localparam int BE_W    = DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [BE_W-1:0]      req_be,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  input  logic [NUM_CS*TW-1:0] cfg_rd_setup,
  input  logic [NUM_CS*TW-1:0] cfg_rd_strobe,
  input  logic [NUM_CS*TW-1:0] cfg_rd_hold,
  input  logic [NUM_CS*TW-1:0] cfg_wr_setup,
  input  logic [NUM_CS*TW-1:0] cfg_wr_strobe,
  input  logic [NUM_CS*TW-1:0] cfg_wr_hold,
  input  logic [NUM_CS*TW-1:0] cfg_turn,
  input  logic [NUM_CS-1:0]    cfg_sel_strobe,
  input  logic [NUM_CS-1:0]    cfg_ext_wait,
  input  logic [NUM_CS-1:0]    cfg_wide,
  input  logic [NUM_CS-1:0]    mem_wait,
  input  logic [DW-1:0]        mem_din,
  output logic [NUM_CS-1:0]    mem_cs_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [OFF_W-1:0]     mem_addr,
  output logic [DW-1:0]        mem_dout,
  output logic                 mem_dout_en,
  output logic [BE_W-1:0]      mem_be_n
);

  function automatic logic [DW-1:0] data_keep(input logic wide);
    return wide ? {DW{1'b1}} : {{(DW/2){1'b0}}, {(DW/2){1'b1}}};
  endfunction

  function automatic logic [BE_W-1:0] be_keep(input logic wide);
    return wide ? {BE_W{1'b1}} : {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  endfunction

  logic [CS_BITS-1:0] dec_cs, cur_cs;
  logic [OFF_W-1:0]   dec_off, cur_offset;
  logic [TW-1:0]      dec_setup, dec_strobe, dec_hold, dec_turn;
  logic               dec_ss, dec_ew, dec_wide;
  logic [NUM_CS-1:0]  wait_sync;
  phase_e             phase;
  logic               cur_write, cur_ss, cur_wide;
  logic [DW-1:0]      cur_wdata;
  logic [BE_W-1:0]    cur_be;
  logic               ev_accept, ev_extend, ev_capture, ev_done;
  logic               ev_active, ev_strobe;

  amc_cs_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .TW(TW)) u_dec (
    .addr(req_addr), .write(req_write),
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .turn(cfg_turn), .sel_strobe(cfg_sel_strobe), .ext_wait(cfg_ext_wait), .wide(cfg_wide),
    .cs_idx(dec_cs), .offset(dec_off), .setup_len(dec_setup), .strobe_len(dec_strobe),
    .hold_len(dec_hold), .turn_len(dec_turn), .ss_en(dec_ss), .ew_en(dec_ew), .wide_en(dec_wide)
  );

  amc_wait_sync #(.NUM_CS(NUM_CS)) u_sync (
    .clk(clk), .rst_n(rst_n), .wait_pin(mem_wait), .wait_sync(wait_sync)
  );

  amc_seq #(.NUM_CS(NUM_CS), .TW(TW), .OFF_W(OFF_W), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(dec_off), .req_wdata(req_wdata), .req_be(req_be),
    .dec_cs(dec_cs), .dec_setup(dec_setup), .dec_strobe(dec_strobe), .dec_hold(dec_hold),
    .dec_turn(dec_turn), .dec_ss(dec_ss), .dec_ew(dec_ew), .dec_wide(dec_wide),
    .wait_sync(wait_sync), .mem_din(mem_din),
    .phase(phase), .req_ready(req_ready), .cur_cs(cur_cs), .cur_write(cur_write),
    .cur_ss(cur_ss), .cur_wide(cur_wide), .cur_offset(cur_offset), .cur_wdata(cur_wdata),
    .cur_be(cur_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ev_accept(ev_accept), .ev_extend(ev_extend), .ev_capture(ev_capture), .ev_done(ev_done)
  );

  assign ev_active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign ev_strobe = (phase == PH_STROBE);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    logic hit;
    assign hit         = (cur_cs == CS_BITS'(g));
    assign mem_cs_n[g] = !(hit && (cur_ss ? ev_strobe : ev_active));
  end

  assign mem_oe_n    = !(ev_strobe && !cur_write);
  assign mem_we_n    = !(ev_strobe && cur_write);
  assign mem_addr    = cur_offset;
  assign mem_dout    = cur_wdata & data_keep(cur_wide);
  assign mem_dout_en = ev_active && cur_write;
  assign mem_be_n    = ev_active ? ~(cur_be & be_keep(cur_wide)) : {BE_W{1'b1}};

endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int NUM_CS = 4,
  parameter int OFF_W  = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [OFF_W-1:0]  mem_addr,
  input logic              ev_active,
  input logic              ev_strobe,
  input logic              ev_accept,
  input logic              ev_extend,
  input logic              ev_capture,
  input logic              ev_done,
  input logic              cur_ss
);

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_active && $past(ev_active) && !$past(ev_done)) |-> $stable(mem_addr));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_active |-> !req_ready);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (rsp_valid && req_ready));

  assert_capture_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> (mem_oe_n && mem_we_n));

  assert_extend_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extend |=> ev_strobe);

  assert_ss_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_active && !ev_strobe && cur_ss) |-> (&mem_cs_n));

endmodule

bind async_mem_ctrl amc_checker #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
  .ev_active(ev_active), .ev_strobe(ev_strobe), .ev_accept(ev_accept),
  .ev_extend(ev_extend), .ev_capture(ev_capture), .ev_done(ev_done), .cur_ss(cur_ss)
);

// File: tb/tb_async_mem_ctrl.sv
module tb_async_mem_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid;
  logic [27:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, mem_din = '0, mem_dout;
  logic [1:0]  req_be = '0, mem_be_n;
  logic [15:0] cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold;
  logic [15:0] cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold, cfg_turn;
  logic [3:0]  cfg_sel_strobe, cfg_ext_wait, cfg_wide;
  logic [3:0]  mem_wait = '0, mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dout_en;
  logic [25:0] mem_addr;

  async_mem_ctrl dut (.*);

  // Per chip select settings: read S/T/H, write S/T/H, turnaround, modes.
  int rs[4] = '{2, 0, 1, 1};
  int rt[4] = '{3, 0, 2, 2};
  int rh[4] = '{1, 0, 1, 1};
  int ws[4] = '{1, 0, 1, 1};
  int wt[4] = '{2, 0, 1, 2};
  int wh[4] = '{2, 0, 1, 1};
  int tn[4] = '{2, 3, 1, 0};
  bit ss[4] = '{0, 0, 1, 0};
  bit ew[4] = '{0, 0, 0, 1};
  bit wd[4] = '{1, 1, 1, 0};

  initial begin
    for (int i = 0; i < 4; i++) begin
      cfg_rd_setup[i*4 +: 4]  = 4'(rs[i]);
      cfg_rd_strobe[i*4 +: 4] = 4'(rt[i]);
      cfg_rd_hold[i*4 +: 4]   = 4'(rh[i]);
      cfg_wr_setup[i*4 +: 4]  = 4'(ws[i]);
      cfg_wr_strobe[i*4 +: 4] = 4'(wt[i]);
      cfg_wr_hold[i*4 +: 4]   = 4'(wh[i]);
      cfg_turn[i*4 +: 4]      = 4'(tn[i]);
      cfg_sel_strobe[i] = ss[i];
      cfg_ext_wait[i]   = ew[i];
      cfg_wide[i]       = wd[i];
    end
  end

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int min1(input int v);
    return (v > 0) ? v : 1;
  endfunction

  // Results of the last measured access.
  int m_pre, m_stb, m_post, m_cs, m_bad_addr, m_bad_other, m_bad_ready, m_bad_dout, m_bad_be;
  logic [15:0] m_rdata;
  bit m_ready_at_rsp;

  task automatic run_access(input int cs, input bit wr, input logic [25:0] off,
                            input logic [15:0] wdata, input logic [1:0] be,
                            input logic [15:0] din_a, input int wait_k);
    bit seen_stb = 0, done_stb = 0, got = 0;
    logic [15:0] exp_dout = wd[cs] ? wdata : {8'h00, wdata[7:0]};
    logic [1:0]  exp_ben  = wd[cs] ? ~be : {1'b1, ~be[0]};
    m_pre = 0; m_stb = 0; m_post = 0; m_cs = 0;
    m_bad_addr = 0; m_bad_other = 0; m_bad_ready = 0; m_bad_dout = 0; m_bad_be = 0;
    while (!req_ready) @(negedge clk);
    mem_din   = din_a;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {2'(cs), off};
    req_wdata = wdata;
    req_be    = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int s = 0; s < 200 && !got; s++) begin
      if (rsp_valid) begin
        got = 1;
        m_rdata = rsp_rdata;
        m_ready_at_rsp = req_ready;
      end else begin
        bit stb_now = wr ? !mem_we_n : !mem_oe_n;
        bit other   = wr ? !mem_oe_n : !mem_we_n;
        if (!req_ready) ; else m_bad_ready++;
        if (other) m_bad_other++;
        for (int c = 0; c < 4; c++)
          if (c != cs && !mem_cs_n[c]) m_bad_other++;
        if (!mem_cs_n[cs]) begin
          m_cs++;
          if (mem_addr != off) m_bad_addr++;
        end
        if (stb_now) begin
          seen_stb = 1;
          m_stb++;
          if (wr && (!mem_dout_en || mem_dout != exp_dout)) m_bad_dout++;
          if (mem_be_n != exp_ben) m_bad_be++;
          if (wait_k > 0 && m_stb == wait_k) mem_wait[cs] = 1'b0;
        end else if (seen_stb) begin
          if (!done_stb) mem_din = ~din_a;
          done_stb = 1;
          m_post++;
        end else begin
          m_pre++;
        end
        @(negedge clk);
      end
    end
    check(got, "R9", "response seen", 64'(got), 1);
  endtask

  task automatic check_shape(input string tag, input int cs, input bit wr, input int gap,
                             input int ext_stb);
    int s_len = wr ? min1(ws[cs]) : min1(rs[cs]);
    int t_len = (ext_stb > 0) ? ext_stb : (wr ? min1(wt[cs]) : min1(rt[cs]));
    int h_len = wr ? min1(wh[cs]) : min1(rh[cs]);
    check(m_pre == gap + s_len, tag, "gap+setup cycles", m_pre, gap + s_len);
    check(m_stb == t_len, tag, "strobe cycles", m_stb, t_len);
    check(m_post == h_len, tag, "hold cycles", m_post, h_len);
    check(m_cs == (ss[cs] ? t_len : s_len + t_len + h_len), tag, "cs low cycles", m_cs,
          ss[cs] ? t_len : s_len + t_len + h_len);
    check(m_bad_addr == 0, "R1", "addr mismatches", m_bad_addr, 0);
    check(m_bad_other == 0, "R10", "wrong cs/strobe low", m_bad_other, 0);
    check(m_bad_ready == 0 && m_ready_at_rsp, "R9", "ready busy/return", m_bad_ready, 0);
    if (wr) begin
      check(m_bad_dout == 0, "R10", "write data/enable", m_bad_dout, 0);
      check(m_bad_be == 0, "R7", "byte enables", m_bad_be, 0);
    end
  endtask

  task automatic t_reset;
    check(mem_cs_n == 4'hF, "R11", "cs_n after reset", mem_cs_n, 4'hF);
    check(mem_oe_n && mem_we_n, "R11", "strobes after reset", {mem_oe_n, mem_we_n}, 2'b11);
    check(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R11", "rsp after reset", rsp_valid, 0);
  endtask

  task automatic t_read_first;   // R2, R8: first access, no gap
    run_access(0, 0, 26'h0123456, 16'h0, 2'b11, 16'h5A3C, 0);
    check_shape("R2", 0, 0, 0, 0);
    check(m_rdata == 16'h5A3C, "R8", "read data", m_rdata, 16'h5A3C);
  endtask

  task automatic t_same_dir;     // R4: read after read, same cs
    run_access(0, 0, 26'h3FFFFFF, 16'h0, 2'b11, 16'h1234, 0);
    check_shape("R4", 0, 0, 0, 0);
    check(m_rdata == 16'h1234, "R8", "read data", m_rdata, 16'h1234);
  endtask

  task automatic t_dir_change;   // R4: read then write on cs0
    run_access(0, 1, 26'h0000010, 16'hBEEF, 2'b11, 16'h0, 0);
    check_shape("R4", 0, 1, tn[0], 0);
  endtask

  task automatic t_zero_timing;  // R3: all zero lengths on cs1
    run_access(1, 0, 26'h2AAAAAA, 16'h0, 2'b11, 16'hC0DE, 0);
    check_shape("R3", 1, 0, tn[1], 0);
    check(m_rdata == 16'hC0DE, "R8", "read data", m_rdata, 16'hC0DE);
  endtask

  task automatic t_sel_strobe;   // R5
    run_access(2, 0, 26'h1555555, 16'h0, 2'b11, 16'h7E81, 0);
    check_shape("R5", 2, 0, tn[2], 0);
  endtask

  task automatic t_wait_extend;  // R6, R7: narrow read with wait released on strobe 4
    mem_wait[3] = 1'b1;
    repeat (3) @(negedge clk);
    run_access(3, 0, 26'h0000777, 16'h0, 2'b11, 16'hABCD, 4);
    check_shape("R6", 3, 0, 0, 6);
    check(m_rdata == 16'h00CD, "R7", "narrow read data", m_rdata, 16'h00CD);
  endtask

  task automatic t_narrow_write; // R7, R4 with zero turnaround
    run_access(3, 1, 26'h0000778, 16'h9966, 2'b11, 16'h0, 0);
    check_shape("R7", 3, 1, 0, 0);
  endtask

  task automatic t_wait_ignored; // R6: wait pin high, mode off on cs0
    mem_wait[0] = 1'b1;
    repeat (3) @(negedge clk);
    run_access(0, 0, 26'h0000042, 16'h0, 2'b11, 16'h4242, 0);
    check_shape("R6", 0, 0, tn[0], 0);
    mem_wait[0] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_first();
    t_same_dir();
    t_dir_change();
    t_zero_timing();
    t_sel_strobe();
    t_wait_extend();
    t_narrow_write();
    t_wait_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule